// File: doc/BRIEF.md
# Pulse-Length Coded Output Encoder

This block drives the single current-select line of a two-level current interface. For every accepted edge event it sends one pulse. The pulse opens with a fixed interval in which the line is forced low. A high interval follows, and its length tells the receiver what kind of event it was. The high interval lasts one base unit for a plain speed event, two units for motion to the left, and four units for motion to the right. The block runs on a 2 MHz tick, so each default interval of 60 clocks lasts 30 µs.

Events arrive as a one-cycle strobe that carries a type code, an edge polarity bit and a mute bit. A calibrated-mode level comes in alongside them. Falling edges and muted events are discarded. Before calibration only a small startup budget of pulses may go out. The first pulse after reset is always sent as a speed pulse, because no direction history exists yet. If a strobe arrives while a pulse is in flight, it is dropped and a sticky overrun flag is set. A busy output shows when a pulse sequence is running.

Top module: `pulse_code_enc`

## Requirements
- R1: After reset, `cur_hi`, `busy` and `overrun` are all low.
- R2: An accepted event holds `cur_hi` low for exactly GAP_TICKS (60) clocks, with `busy` high, before the high interval begins.
- R3: Type code 2'b00 (speed), and also the code 2'b11, gives a high interval of UNIT_TICKS (60) clocks.
- R4: Type code 2'b01 (left) gives a high interval of 2×UNIT_TICKS (120) clocks.
- R5: Type code 2'b10 (right) gives a high interval of 4×UNIT_TICKS (240) clocks.
- R6: A strobe with `evt_rising` low produces no pulse.
- R7: A strobe with `evt_mute` high produces no pulse.
- R8: While `cal_done` is low, at most STARTUP_PULSES (2) pulses are sent after reset, and further uncalibrated events are dropped. Once `cal_done` is high, events are accepted again.
- R9: The first pulse after reset has the speed length, whatever its type code.
- R10: A strobe that arrives while `busy` is high is dropped. The pulse in flight keeps its length, and `overrun` goes high and stays high until reset.
- R11: `busy` rises in the clock after acceptance and falls together with `cur_hi` at the end of the high interval. A strobe in the first cycle with `busy` low is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2 MHz tick clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_stb | input | 1 | One-cycle edge event strobe |
| evt_kind | input | 2 | Pulse type: 00 speed, 01 left, 10 right, 11 speed |
| evt_rising | input | 1 | High when the event is a rising magnetic edge |
| evt_mute | input | 1 | Suppress request for this event |
| cal_done | input | 1 | Calibrated-mode level |
| cur_hi | output | 1 | High-current select |
| busy | output | 1 | Pulse sequence in progress |
| overrun | output | 1 | Sticky flag: an event arrived while busy |

## Verification
The main function is first driven with each type code in turn, with both codes that map to speed included. Measuring the low count and the high count separately tells a wrong gap length apart from a wrong unit multiple. A sequence that starts uncalibrated checks several things: that the first-pulse override replaces a right code with a speed length, that the startup budget stops the third pulse, and that calibration lets events through again. Muted strobes, falling-edge strobes and a strobe injected in the middle of a pulse show that each rejection path leaves the output idle, or leaves the pulse in flight intact. A strobe placed exactly in the cycle where `busy` falls probes the boundary of acceptance. Random mixes of all these inputs are checked against a bench model of the startup budget and the first-pulse rule.

// File: rtl/pce_pkg.sv
package pce_pkg;

  typedef enum logic [1:0] {
    KIND_SPEED = 2'b00,
    KIND_LEFT  = 2'b01,
    KIND_RIGHT = 2'b10,
    KIND_ALT   = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_GAP  = 2'b01,
    ST_HIGH = 2'b10
  } seq_e;

  // unit multiple as a left-shift amount
  function automatic logic [1:0] kind_shift(input kind_e k);
    case (k)
      KIND_LEFT:  kind_shift = 2'd1;
      KIND_RIGHT: kind_shift = 2'd2;
      default:    kind_shift = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/pce_rst_sync.sv
module pce_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pce_admit.sv
module pce_admit
  import pce_pkg::*;
#(
  parameter int STARTUP_PULSES = 2,
  localparam int SU_W = $clog2(STARTUP_PULSES + 2)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_stb,
  input  logic [1:0] evt_kind,
  input  logic       evt_rising,
  input  logic       evt_mute,
  input  logic       cal_done,
  input  logic       seq_idle,
  output logic       take,
  output logic [1:0] take_shift,
  output logic       overrun
);

  logic            first_q, first_d;
  logic [SU_W-1:0] su_q, su_d;
  logic            ovr_q, ovr_d;
  logic            cand, budget_ok;

  always_comb begin
    cand      = evt_stb && evt_rising && !evt_mute;
    budget_ok = cal_done || (su_q < SU_W'(STARTUP_PULSES));
    take      = cand && seq_idle && budget_ok;

    take_shift = kind_shift(kind_e'(evt_kind));
    if (!first_q) take_shift = 2'd0;

    first_d = first_q | take;

    su_d = su_q;
    if (take && !cal_done) su_d = su_q + SU_W'(1);

    ovr_d = ovr_q | (evt_stb && !seq_idle);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      su_q    <= '0;
      ovr_q   <= 1'b0;
    end else begin
      first_q <= first_d;
      su_q    <= su_d;
      ovr_q   <= ovr_d;
    end
  end

  assign overrun = ovr_q;

endmodule

// File: rtl/pce_seq.sv
module pce_seq
  import pce_pkg::*;
#(
  parameter int GAP_TICKS  = 60,
  parameter int UNIT_TICKS = 60,
  localparam int CNT_W = $clog2(4*UNIT_TICKS + GAP_TICKS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic [1:0] take_shift,
  output logic       seq_idle,
  output logic       busy,
  output logic       cur_hi
);

  seq_e             st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       sh_q;
  logic             sh_en;
  logic [CNT_W-1:0] hi_len;

  always_comb begin
    hi_len = CNT_W'(UNIT_TICKS) << sh_q;
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_en  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (take) begin
          st_d  = ST_GAP;
          cnt_d = CNT_W'(GAP_TICKS - 1);
          sh_en = 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt_q == '0) begin
          st_d  = ST_HIGH;
          cnt_d = hi_len - CNT_W'(1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_HIGH: begin
        if (cnt_q == '0) st_d = ST_IDLE;
        else             cnt_d = cnt_q - CNT_W'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= 2'd0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (sh_en) sh_q <= take_shift;
    end
  end

  assign seq_idle = (st_q == ST_IDLE);
  assign busy     = !seq_idle;
  assign cur_hi   = (st_q == ST_HIGH);

endmodule

// File: rtl/pulse_code_enc.sv
module pulse_code_enc #(
  parameter int GAP_TICKS      = 60,
  parameter int UNIT_TICKS     = 60,
  parameter int STARTUP_PULSES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_stb,
  input  logic [1:0] evt_kind,
  input  logic       evt_rising,
  input  logic       evt_mute,
  input  logic       cal_done,
  output logic       cur_hi,
  output logic       busy,
  output logic       overrun
);

  logic       rst_n_s;
  logic       take;
  logic [1:0] take_shift;
  logic       seq_idle;

  pce_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  pce_admit #(.STARTUP_PULSES(STARTUP_PULSES)) u_admit (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .evt_stb    (evt_stb),
    .evt_kind   (evt_kind),
    .evt_rising (evt_rising),
    .evt_mute   (evt_mute),
    .cal_done   (cal_done),
    .seq_idle   (seq_idle),
    .take       (take),
    .take_shift (take_shift),
    .overrun    (overrun)
  );

  pce_seq #(.GAP_TICKS(GAP_TICKS), .UNIT_TICKS(UNIT_TICKS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .take       (take),
    .take_shift (take_shift),
    .seq_idle   (seq_idle),
    .busy       (busy),
    .cur_hi     (cur_hi)
  );

endmodule

// File: rtl/pce_chk.sv
module pce_chk #(
  parameter int GAP_TICKS = 60
) (
  input logic clk,
  input logic rst_n,
  input logic evt_stb,
  input logic evt_rising,
  input logic evt_mute,
  input logic cur_hi,
  input logic busy,
  input logic overrun
);

  logic [15:0] gap_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              gap_run <= '0;
    else if (busy && !cur_hi) gap_run <= gap_run + 16'd1;
    else                      gap_run <= '0;
  end

  p_gap_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !cur_hi);

  p_gap_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cur_hi) |-> (gap_run == 16'(GAP_TICKS)));

  p_fall_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_stb && !evt_rising && !busy) |=> !busy);

  p_mute_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_stb && evt_mute && !busy) |=> !busy);

  p_ovr_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_stb && busy) |=> overrun);

  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_high_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cur_hi |-> busy);

  p_end_together_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cur_hi) |-> !busy);

endmodule

bind pulse_code_enc pce_chk #(.GAP_TICKS(GAP_TICKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_stb    (evt_stb),
  .evt_rising (evt_rising),
  .evt_mute   (evt_mute),
  .cur_hi     (cur_hi),
  .busy       (busy),
  .overrun    (overrun)
);

// File: tb/sim_pulse_code_enc.sv
`timescale 1ns/1ps
module sim_pulse_code_enc;

  localparam int GAP  = 60;
  localparam int UNIT = 60;
  localparam int SUP  = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       evt_stb;
  logic [1:0] evt_kind;
  logic       evt_rising;
  logic       evt_mute;
  logic       cal_done;
  logic       cur_hi, busy, overrun;

  int n_total = 0;
  int n_fail  = 0;
  bit first_done;
  int su_used;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pulse_code_enc #(.GAP_TICKS(GAP), .UNIT_TICKS(UNIT), .STARTUP_PULSES(SUP)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_stb(evt_stb), .evt_kind(evt_kind),
    .evt_rising(evt_rising), .evt_mute(evt_mute), .cal_done(cal_done),
    .cur_hi(cur_hi), .busy(busy), .overrun(overrun)
  );

  function automatic int exp_high(input logic [1:0] k, input bit first);
    if (!first) return UNIT;
    case (k)
      2'b01:   return 2*UNIT;
      2'b10:   return 4*UNIT;
      default: return UNIT;
    endcase
  endfunction

  function automatic bit exp_accept(input bit rise, input bit mute, input bit cal, input int used);
    return rise && !mute && (cal || used < SUP);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    evt_stb = 1'b0; evt_kind = 2'b00; evt_rising = 1'b0; evt_mute = 1'b0; cal_done = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    first_done = 1'b0;
    su_used = 0;
  endtask

  task automatic run_evt(input logic [1:0] k, input bit rise, input bit mute, input bit cal,
                         input int inject_at, input bit immediate, input string req);
    bit take;
    int ehi;
    bit ovr_before;
    int lows;
    int highs;
    int n;
    take = exp_accept(rise, mute, cal, su_used);
    ehi = exp_high(k, first_done);
    ovr_before = overrun;
    if (!immediate) @(negedge clk);
    evt_stb = 1'b1; evt_kind = k; evt_rising = rise; evt_mute = mute; cal_done = cal;
    @(negedge clk);
    evt_stb = 1'b0;
    lows = 0; highs = 0; n = 0;
    while (busy && n < 1000) begin
      if (cur_hi) highs++; else lows++;
      evt_stb = (n == inject_at);
      n++;
      @(negedge clk);
    end
    evt_stb = 1'b0;
    if (take) begin
      chk(lows == GAP, "R2 gap length", lows, GAP);
      chk(highs == ehi, req, highs, ehi);
      first_done = 1'b1;
      if (!cal) su_used++;
    end else begin
      chk(lows + highs == 0, req, lows + highs, 0);
      chk(overrun == ovr_before, {req, " overrun untouched"}, overrun, ovr_before);
    end
    if (inject_at >= 0 && take)
      chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_total++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4953));
    do_reset();
    chk(cur_hi == 1'b0, "R1 cur_hi", cur_hi, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);

    run_evt(2'b10, 1, 0, 0, -1, 0, "R9 first pulse speed");
    run_evt(2'b01, 1, 0, 0, -1, 0, "R4 left uncal");
    run_evt(2'b00, 1, 0, 0, -1, 0, "R8 startup budget");
    run_evt(2'b10, 1, 0, 1, -1, 0, "R5 right");
    run_evt(2'b11, 1, 0, 1, -1, 0, "R3 code 11");
    run_evt(2'b00, 1, 0, 1, -1, 0, "R3 code 00");
    run_evt(2'b01, 0, 0, 1, -1, 0, "R6 falling edge");
    run_evt(2'b01, 1, 1, 1, -1, 0, "R7 muted");
    chk(overrun == 1'b0, "R10 no early overrun", overrun, 0);
    run_evt(2'b10, 1, 0, 1, 20, 0, "R10 pulse kept");
    run_evt(2'b01, 1, 0, 1, -1, 1, "R11 back-to-back");
    run_evt(2'b00, 1, 0, 1, 100, 0, "R10 inject in high");
    chk(overrun == 1'b1, "R10 sticky", overrun, 1);

    for (int i = 0; i < 60; i++) begin
      logic [1:0] k;
      bit r, m;
      int inj;
      k = 2'($urandom_range(0, 3));
      r = ($urandom_range(0, 5) != 0);
      m = ($urandom_range(0, 5) == 0);
      inj = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 50)) : -1;
      run_evt(k, r, m, 1, inj, $urandom_range(0, 3) == 0, "R3 R4 R5 random");
    end

    do_reset();
    chk(overrun == 1'b0, "R1 overrun cleared", overrun, 0);
    run_evt(2'b01, 1, 0, 0, -1, 0, "R9 first after re-reset");
    run_evt(2'b10, 1, 0, 0, -1, 0, "R5 second uncal");
    run_evt(2'b10, 1, 0, 0, -1, 0, "R8 budget again");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule